// File: doc/BRIEF.md
# Exponentiation Engine Host Port

This block is the host-side register and operand port of a modular exponentiation engine. A processor talks to it over an AXI4-Lite slave interface. Each address is decoded into a typed region: the modulus store, four operand stores, a push port into the exponent queue, and a single control word. Operand and modulus words are written 32 bits at a time into a small behavioural store that stands in for the engine's operand memories. The queue storage and the arithmetic engine are outside the block and are reached only through ports.

Reads from the operand regions do not return the addressed operand. They always return the word at the requested index of the operand that the control word names as destination, which is where the engine leaves its results. The fields of the control word drive the engine's select and mode inputs directly. Writing the start bit from 0 to 1 produces a single start pulse. A rising completion signal from the engine comes back as a one-cycle interrupt.

Top module: `modexp_host_if`

## Requirements
- R1: An address is decoded only when bits [31:16] equal the base parameter (default 0xA000), bit 15 is 0, bits [11:8] are 0, and bits [14:12] hold a region code from 0 to 6. Any other address gets response 2'b10 and has no effect: no store word, control field or queue push changes, and a read returns data 0.
- R2: Every write and every read to a decoded address completes with response 2'b00.
- R3: A write to region 0 (modulus) or to regions 1..4 (operands 0..3) stores the 32-bit data at word index bits [7:2]. Bits [1:0] are ignored.
- R4: A read from any of regions 1..4 returns the word at index bits [7:2] of the operand chosen by the destination field (0..3 → region 1..4). A read from region 0 or region 5 returns 0. Read data is held stable until RREADY.
- R5: Control word (region 6) layout: [31:30] pipeline select, [29:28] destination, [27:26] x select, [25:24] y select, [23] start, [22] exponent mode, [21] modulus select. The fields drive the matching outputs from the cycle after the write, and a read of region 6 returns the stored word.
- R6: A control write that takes bit 23 from 0 to 1 raises eng_start for exactly one cycle, in the cycle in which BVALID rises. Writing 1 while the bit is already 1 gives no pulse.
- R7: A write to region 5 raises fifo_push for one cycle with fifo_data equal to the written word.
- R8: The address and data of a write may arrive in either order or together. BVALID rises once both are held, stays high until BREADY, and no new address or data is accepted while it is high.
- R9: A rising edge on eng_done raises irq for exactly one cycle, in the following cycle.
- R10: A read accepted on the same clock edge as a control write uses the destination field that was in force before that write.
- R11: After reset, AWREADY, WREADY and ARREADY are 1, BVALID, RVALID, irq, eng_start and fifo_push are 0, and all control outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | 32 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 32 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| eng_pipe_sel | output | 2 | Pipeline width select |
| eng_dest_sel | output | 2 | Destination operand |
| eng_x_sel | output | 2 | x operand select |
| eng_y_sel | output | 2 | y operand select |
| eng_start | output | 1 | One-cycle start pulse |
| eng_exp_mode | output | 1 | Exponentiation mode |
| eng_mod_sel | output | 1 | Modulus select |
| fifo_push | output | 1 | Exponent queue push strobe |
| fifo_data | output | 32 | Word pushed into the queue |
| eng_done | input | 1 | Engine completion |
| irq | output | 1 | Completion interrupt pulse |

## Verification
Two functions can fall on the same clock edge: a control write that changes the destination field, and acceptance of a read that depends on that field. The bench drives a full control write and an operand read in the same cycle on an idle bus. Both are accepted at one edge. The bench expects the read data to come from the old destination, and a second read afterwards to come from the new one. Random operand traffic with shuffled address and data ordering sits around this directed collision, and its values are checked against a bench-side model of every store.

// File: rtl/mh_pkg.sv
package mh_pkg;
    parameter int DATA_W     = 32;
    parameter int ADDR_W     = 32;
    parameter int BASE_W     = 16;
    parameter int REGION_W   = 3;
    parameter int WORD_IDX_W = 6;
    parameter int RESP_W     = 2;
    localparam int WORDS     = 1 << WORD_IDX_W;
    localparam int NUM_BANKS = 5;

    typedef enum logic [REGION_W-1:0] {
        RG_MOD  = 3'd0,
        RG_OP0  = 3'd1,
        RG_OP1  = 3'd2,
        RG_OP2  = 3'd3,
        RG_OP3  = 3'd4,
        RG_EXPQ = 3'd5,
        RG_CTRL = 3'd6,
        RG_NONE = 3'd7
    } region_e;

    typedef struct packed {
        logic [1:0]  pipe;
        logic [1:0]  dest;
        logic [1:0]  xsel;
        logic [1:0]  ysel;
        logic        start;
        logic        exp_mode;
        logic        mod_sel;
        logic [20:0] spare;
    } ctrl_t;

    typedef struct packed {
        region_e               region;
        logic [WORD_IDX_W-1:0] idx;
        logic                  hit;
    } dec_t;

    localparam logic [RESP_W-1:0] RESP_OKAY   = 2'b00;
    localparam logic [RESP_W-1:0] RESP_SLVERR = 2'b10;

    function automatic logic [REGION_W-1:0] dest_bank(input logic [1:0] dest);
        return {1'b0, dest} + 3'd1;
    endfunction
endpackage

// File: rtl/mh_addr_decode.sv
module mh_addr_decode
    import mh_pkg::*;
#(
    parameter logic [BASE_W-1:0] BASE = 16'hA000
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    logic unused_lsb;
    assign unused_lsb = ^addr[1:0];

    always_comb begin
        dec.region = region_e'(addr[14:12]);
        dec.idx    = addr[2 +: WORD_IDX_W];
        dec.hit    = (addr[ADDR_W-1 -: BASE_W] == BASE) && !addr[15]
                   && (addr[11:8] == 4'd0) && (addr[14:12] != RG_NONE);
    end
endmodule

// File: rtl/mh_ctrl_reg.sv
module mh_ctrl_reg
    import mh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl_q,
    output logic              start_pulse
);
    ctrl_t nxt;
    assign nxt = ctrl_t'(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q      <= '0;
            start_pulse <= 1'b0;
        end else begin
            start_pulse <= we && nxt.start && !ctrl_q.start;
            if (we) ctrl_q <= nxt;
        end
    end
endmodule

// File: rtl/mh_opnd_store.sv
module mh_opnd_store
    import mh_pkg::*;
#(
    parameter int BANKS = NUM_BANKS,
    parameter int IDX_W = WORD_IDX_W
) (
    input  logic                clk,
    input  logic                we,
    input  logic [REGION_W-1:0] wbank,
    input  logic [IDX_W-1:0]    widx,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [REGION_W-1:0] rbank,
    input  logic [IDX_W-1:0]    ridx,
    output logic [DATA_W-1:0]   rdata
);
    localparam int DEPTH = 1 << IDX_W;
    logic [DATA_W-1:0] bank_rd [BANKS];

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        logic [DATA_W-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (we && wbank == REGION_W'(g)) mem[widx] <= wdata;
        end
        assign bank_rd[g] = mem[ridx];
    end

    always_comb begin
        rdata = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (rbank == REGION_W'(b)) rdata = bank_rd[b];
        end
    end
endmodule

// File: rtl/modexp_host_if.sv
module modexp_host_if
    import mh_pkg::*;
#(
    parameter logic [BASE_W-1:0] BASE_ADDR_HI = 16'hA000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [RESP_W-1:0] s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [RESP_W-1:0] s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic [1:0]        eng_pipe_sel,
    output logic [1:0]        eng_dest_sel,
    output logic [1:0]        eng_x_sel,
    output logic [1:0]        eng_y_sel,
    output logic              eng_start,
    output logic              eng_exp_mode,
    output logic              eng_mod_sel,
    output logic              fifo_push,
    output logic [DATA_W-1:0] fifo_data,
    input  logic              eng_done,
    output logic              irq
);
    // write path: address and data held independently until both present
    logic              aw_held, w_held;
    logic [ADDR_W-1:0] aw_q;
    logic [DATA_W-1:0] w_q;
    logic              aw_take, w_take, wr_go;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    dec_t              wdec, rdec;
    logic              mem_we, ctrl_we, q_we;
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] store_rd;
    logic              ar_take;
    logic              done_q;

    assign s_awready = !aw_held && !s_bvalid;
    assign s_wready  = !w_held && !s_bvalid;
    assign aw_take   = s_awvalid && s_awready;
    assign w_take    = s_wvalid && s_wready;
    assign wr_addr   = aw_held ? aw_q : s_awaddr;
    assign wr_data   = w_held ? w_q : s_wdata;
    assign wr_go     = (aw_held || aw_take) && (w_held || w_take);

    mh_addr_decode #(.BASE(BASE_ADDR_HI)) u_wdec (.addr(wr_addr),  .dec(wdec));
    mh_addr_decode #(.BASE(BASE_ADDR_HI)) u_rdec (.addr(s_araddr), .dec(rdec));

    assign mem_we  = wr_go && wdec.hit && (wdec.region <= RG_OP3);
    assign ctrl_we = wr_go && wdec.hit && (wdec.region == RG_CTRL);
    assign q_we    = wr_go && wdec.hit && (wdec.region == RG_EXPQ);

    mh_ctrl_reg u_ctrl (
        .clk(clk), .rst(rst), .we(ctrl_we), .wdata(wr_data),
        .ctrl_q(ctrl_q), .start_pulse(eng_start)
    );

    mh_opnd_store u_store (
        .clk(clk), .we(mem_we), .wbank(wdec.region), .widx(wdec.idx),
        .wdata(wr_data), .rbank(dest_bank(ctrl_q.dest)), .ridx(rdec.idx),
        .rdata(store_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            aw_held   <= 1'b0;
            w_held    <= 1'b0;
            aw_q      <= '0;
            w_q       <= '0;
            s_bvalid  <= 1'b0;
            s_bresp   <= RESP_OKAY;
            fifo_push <= 1'b0;
            fifo_data <= '0;
        end else begin
            fifo_push <= q_we;
            if (q_we) fifo_data <= wr_data;
            if (wr_go) begin
                aw_held  <= 1'b0;
                w_held   <= 1'b0;
                s_bvalid <= 1'b1;
                s_bresp  <= wdec.hit ? RESP_OKAY : RESP_SLVERR;
            end else begin
                if (aw_take) begin
                    aw_held <= 1'b1;
                    aw_q    <= s_awaddr;
                end
                if (w_take) begin
                    w_held <= 1'b1;
                    w_q    <= s_wdata;
                end
                if (s_bvalid && s_bready) s_bvalid <= 1'b0;
            end
        end
    end

    // read path: data captured at address acceptance
    assign s_arready = !s_rvalid;
    assign ar_take   = s_arvalid && s_arready;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_rvalid <= 1'b0;
            s_rdata  <= '0;
            s_rresp  <= RESP_OKAY;
        end else if (ar_take) begin
            s_rvalid <= 1'b1;
            s_rresp  <= rdec.hit ? RESP_OKAY : RESP_SLVERR;
            if (!rdec.hit) begin
                s_rdata <= '0;
            end else begin
                case (rdec.region)
                    RG_OP0, RG_OP1, RG_OP2, RG_OP3: s_rdata <= store_rd;
                    RG_CTRL:                        s_rdata <= ctrl_q;
                    default:                        s_rdata <= '0;
                endcase
            end
        end else if (s_rvalid && s_rready) begin
            s_rvalid <= 1'b0;
        end
    end

    // completion to interrupt
    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            irq    <= 1'b0;
        end else begin
            done_q <= eng_done;
            irq    <= eng_done && !done_q;
        end
    end

    assign eng_pipe_sel = ctrl_q.pipe;
    assign eng_dest_sel = ctrl_q.dest;
    assign eng_x_sel    = ctrl_q.xsel;
    assign eng_y_sel    = ctrl_q.ysel;
    assign eng_exp_mode = ctrl_q.exp_mode;
    assign eng_mod_sel  = ctrl_q.mod_sel;
endmodule

// File: rtl/mh_host_chk.sv
module mh_host_chk
    import mh_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              s_awready,
    input logic              s_wready,
    input logic [RESP_W-1:0] s_bresp,
    input logic              s_bvalid,
    input logic              s_bready,
    input logic [DATA_W-1:0] s_rdata,
    input logic              s_rvalid,
    input logic              s_rready,
    input logic              eng_start,
    input logic              fifo_push,
    input logic              eng_done,
    input logic              irq
);
    AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (rst)
        s_bvalid && !s_bready |=> s_bvalid); // R8
    AST_NO_ACCEPT_IN_RESP: assert property (@(posedge clk) disable iff (rst)
        s_bvalid |-> !s_awready && !s_wready); // R8
    AST_RESP_LEGAL: assert property (@(posedge clk) disable iff (rst)
        s_bvalid |-> (s_bresp == RESP_OKAY || s_bresp == RESP_SLVERR)); // R2
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata)); // R4
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start); // R6
    AST_START_WITH_RESP: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> s_bvalid && s_bresp == RESP_OKAY); // R6
    AST_PUSH_WITH_RESP: assert property (@(posedge clk) disable iff (rst)
        fifo_push |-> s_bvalid && s_bresp == RESP_OKAY); // R7
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R9
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(eng_done)); // R9
endmodule

bind modexp_host_if mh_host_chk u_chk (.*);

// File: tb/tb_modexp_host_if.sv
module tb_modexp_host_if;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] s_awaddr = '0;
    logic        s_awvalid = 1'b0;
    logic        s_awready;
    logic [31:0] s_wdata = '0;
    logic        s_wvalid = 1'b0;
    logic        s_wready;
    logic [1:0]  s_bresp;
    logic        s_bvalid;
    logic        s_bready = 1'b0;
    logic [31:0] s_araddr = '0;
    logic        s_arvalid = 1'b0;
    logic        s_arready;
    logic [31:0] s_rdata;
    logic [1:0]  s_rresp;
    logic        s_rvalid;
    logic        s_rready = 1'b0;
    logic [1:0]  eng_pipe_sel, eng_dest_sel, eng_x_sel, eng_y_sel;
    logic        eng_start, eng_exp_mode, eng_mod_sel;
    logic        fifo_push;
    logic [31:0] fifo_data;
    logic        eng_done = 1'b0;
    logic        irq;

    modexp_host_if dut (.*);

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;
    int start_cnt = 0;
    int push_cnt = 0;
    int irq_cnt = 0;
    logic [31:0] push_last = '0;
    logic [31:0] model [5][64];
    logic [31:0] ctrl_val = '0;

    always @(posedge clk) begin
        if (!rst) begin
            if (eng_start) start_cnt <= start_cnt + 1;
            if (irq) irq_cnt <= irq_cnt + 1;
            if (fifo_push) begin
                push_cnt  <= push_cnt + 1;
                push_last <= fifo_data;
            end
        end
    end

    function automatic logic [31:0] addr_of(input int region, input int idx, input logic [1:0] lsb);
        return {16'hA000, 1'b0, region[2:0], 4'd0, idx[5:0], lsb};
    endfunction

    function automatic int dest_region(input logic [31:0] cv);
        return int'(cv[29:28]) + 1;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic axw(input logic [31:0] a, input logic [31:0] d, input int order,
                       input int bdelay, output logic [1:0] resp);
        bit aw_done, w_done, aw_fire, w_fire;
        aw_done = 0; w_done = 0;
        @(negedge clk);
        if (order != 2) begin s_awaddr = a; s_awvalid = 1; end
        if (order != 1) begin s_wdata = d; s_wvalid = 1; end
        while (!(aw_done && w_done)) begin
            aw_fire = s_awvalid && s_awready;
            w_fire  = s_wvalid && s_wready;
            @(negedge clk);
            if (aw_fire) begin s_awvalid = 0; aw_done = 1; end
            if (w_fire)  begin s_wvalid = 0;  w_done = 1;  end
            if (!aw_done && !s_awvalid) begin s_awaddr = a; s_awvalid = 1; end
            if (!w_done && !s_wvalid)   begin s_wdata = d;  s_wvalid = 1;  end
        end
        while (!s_bvalid) @(negedge clk);
        for (int k = 0; k < bdelay; k++) begin
            chk("R8 bvalid held, address not accepted", {s_bvalid, s_awready, s_wready}, 3'b100);
            @(negedge clk);
        end
        resp = s_bresp;
        s_bready = 1;
        @(negedge clk);
        s_bready = 0;
    endtask

    task automatic axr(input logic [31:0] a, output logic [31:0] d, output logic [1:0] resp);
        @(negedge clk);
        s_araddr = a; s_arvalid = 1;
        while (!s_arready) @(negedge clk);
        @(negedge clk);
        s_arvalid = 0;
        while (!s_rvalid) @(negedge clk);
        d = s_rdata; resp = s_rresp;
        s_rready = 1;
        @(negedge clk);
        s_rready = 0;
    endtask

    task automatic set_ctrl(input logic [31:0] v);
        logic [1:0] r;
        axw(addr_of(6, 0, 2'b00), v, 0, 0, r);
        chk("R2 control write response", {30'd0, r}, 32'd0);
        ctrl_val = v;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d, exp_w;
        logic [1:0]  r;
        int seed_init, s0, p0, i0;
        seed_init = $urandom(32'd20240);
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 0;
        @(negedge clk);
        // R11 reset state
        chk("R11 ready/valid after reset",
            {s_awready, s_wready, s_arready, s_bvalid, s_rvalid, irq, eng_start, fifo_push}, 8'b1110_0000);
        chk("R11 control outputs after reset",
            {eng_pipe_sel, eng_dest_sel, eng_x_sel, eng_y_sel, eng_exp_mode, eng_mod_sel}, 32'd0);

        // R3 fill every bank, mixed orderings and ignored low bits
        for (int b = 0; b < 5; b++) begin
            for (int i = 0; i < 64; i++) begin
                d = $urandom;
                axw(addr_of(b, i, 2'($urandom)), d, int'($urandom % 3), 0, r);
                model[b][i] = d;
                if (r !== 2'b00) chk("R2 operand write response", {30'd0, r}, 32'd0);
            end
        end
        chk("R2 last fill response", {30'd0, r}, 32'd0);

        // R5 control fields
        set_ctrl(32'hE7600000 | 32'h0); // pipe 11 dest 10 x 01 y 11 exp 1 mod 1
        @(negedge clk);
        chk("R5 control fields", {24'd0, eng_pipe_sel, eng_dest_sel, eng_x_sel, eng_y_sel},
            {24'd0, 2'b11, 2'b10, 2'b01, 2'b11});
        chk("R5 mode bits", {30'd0, eng_exp_mode, eng_mod_sel}, 32'd3);
        axr(addr_of(6, 0, 2'b00), d, r);
        chk("R5 control readback", d, 32'hE7600000);

        // R4 random reads from destination operand, R3 lsb ignored
        for (int n = 0; n < 40; n++) begin
            int dsel, idx, reg_a;
            dsel = int'($urandom % 4);
            set_ctrl({2'b11, dsel[1:0], 28'd0});
            idx = int'($urandom % 64);
            reg_a = 1 + int'($urandom % 4);
            axr(addr_of(reg_a, idx, 2'($urandom)), d, r);
            chk("R4 read from destination operand", d, model[dsel + 1][idx]);
            chk("R2 read response", {30'd0, r}, 32'd0);
        end

        // R4 modulus and queue regions read zero
        axr(addr_of(0, 3, 2'b00), d, r);
        chk("R4 modulus region read", {d[31:2], r}, 32'd0);
        axr(addr_of(5, 0, 2'b00), d, r);
        chk("R4 queue region read", {d[31:2], r}, 32'd0);

        // R1 undecoded addresses: error and no effect
        set_ctrl({2'b11, 2'b01, 28'd0});
        s0 = start_cnt; p0 = push_cnt;
        axw(addr_of(2, 9, 2'b00) | 32'h0000_8000, 32'hDEADBEEF, 0, 0, r);
        chk("R1 bit15 set response", {30'd0, r}, 32'd2);
        axw(addr_of(2, 9, 2'b00) | 32'h0000_0400, 32'hDEADBEEF, 1, 0, r);
        chk("R1 bits 11:8 set response", {30'd0, r}, 32'd2);
        axw(addr_of(2, 9, 2'b00) ^ 32'h0001_0000, 32'hDEADBEEF, 2, 0, r);
        chk("R1 base mismatch response", {30'd0, r}, 32'd2);
        axw(addr_of(7, 9, 2'b00), 32'hDEADBEEF, 0, 0, r);
        chk("R1 region 7 response", {30'd0, r}, 32'd2);
        axw(addr_of(6, 0, 2'b00) | 32'h0000_0100, 32'hFF800000, 0, 0, r);
        axw(addr_of(5, 0, 2'b00) | 32'h0000_8000, 32'h12345678, 0, 0, r);
        axr(addr_of(2, 9, 2'b00), d, r);
        chk("R1 operand word unchanged", d, model[2][9]);
        axr(addr_of(6, 0, 2'b00), d, r);
        chk("R1 control unchanged", d, ctrl_val);
        chk("R1 no start or push", {start_cnt - s0, push_cnt - p0}, 64'd0);
        axr(addr_of(7, 0, 2'b00), d, r);
        chk("R1 undecoded read", {d[31:2], r}, {30'd0, 2'b10});

        // R6 start pulse on rising bit only
        s0 = start_cnt;
        set_ctrl(ctrl_val | 32'h0080_0000);
        chk("R6 start pulse on rise", start_cnt - s0, 32'd1);
        set_ctrl(ctrl_val | 32'h0080_0000);
        chk("R6 no pulse while held", start_cnt - s0, 32'd1);
        set_ctrl(ctrl_val & ~32'h0080_0000);
        set_ctrl(ctrl_val | 32'h0080_0000);
        chk("R6 second rise pulses", start_cnt - s0, 32'd2);
        set_ctrl(ctrl_val & ~32'h0080_0000);

        // R7 queue push
        for (int k = 0; k < 3; k++) begin
            p0 = push_cnt;
            exp_w = $urandom;
            axw(addr_of(5, k, 2'b00), exp_w, k, 0, r);
            chk("R7 push count", push_cnt - p0, 32'd1);
            chk("R7 push data", push_last, exp_w);
        end

        // R8 response held under back-pressure
        axw(addr_of(3, 7, 2'b00), 32'hA5A5_0007, 2, 3, r);
        model[3][7] = 32'hA5A5_0007;
        set_ctrl({2'b11, 2'b10, 28'd0});
        axr(addr_of(1, 7, 2'b00), d, r);
        chk("R8 write after data-first order", d, 32'hA5A5_0007);

        // R9 interrupt
        i0 = irq_cnt;
        @(negedge clk) eng_done = 1;
        @(negedge clk);
        chk("R9 irq next cycle", {31'd0, irq}, 32'd1);
        @(negedge clk);
        chk("R9 irq one cycle", {31'd0, irq}, 32'd0);
        @(negedge clk) eng_done = 0;
        @(negedge clk);
        chk("R9 irq count", irq_cnt - i0, 32'd1);

        // R10 collision: destination 0 -> 1, read accepted on the same edge
        set_ctrl({2'b11, 2'b00, 28'd0});
        @(negedge clk);
        s_awaddr = addr_of(6, 0, 2'b00); s_awvalid = 1;
        s_wdata  = {2'b11, 2'b01, 28'd0}; s_wvalid = 1;
        s_araddr = addr_of(4, 5, 2'b00); s_arvalid = 1;
        @(negedge clk);
        s_awvalid = 0; s_wvalid = 0; s_arvalid = 0;
        chk("R10 both accepted", {30'd0, s_bvalid, s_rvalid}, 32'd3);
        chk("R10 read uses old destination", s_rdata, model[1][5]);
        s_rready = 1; s_bready = 1;
        @(negedge clk);
        s_rready = 0; s_bready = 0;
        ctrl_val = {2'b11, 2'b01, 28'd0};
        axr(addr_of(4, 5, 2'b00), d, r);
        chk("R10 later read uses new destination", d, model[2][5]);

        finish_run();
    end
endmodule